// File: doc/BRIEF.md
# Serial Sample Receiver with Asynchronous Handoff

This block takes 8-bit audio samples from a three-wire serial port. The port has a data line, a shift clock and an active-low select. Each complete sample is handed to an unrelated master clock domain. A frame opens when select falls. Bits are taken, most significant first, on rising shift-clock edges while select stays low. A sample counts only when the eighth such edge arrives. If select rises sooner, the partial word is thrown away and the sample already on the output stays in place. Shift-clock edges after the eighth are ignored until select goes high again.

The finished word is latched in a holding register in the shift domain, and a request toggle is flipped. The master domain passes that toggle through a synchronizer and detects its edge. It then copies the holding register into the output sample and raises a one-cycle strobe. The master domain returns an acknowledge toggle through a second synchronizer. Until that acknowledge arrives, the holding register is locked, and a word that completes in the meantime is dropped. The rate of select falling edges is the output sample rate.

Top module: `serial_sample_rx`

## Requirements
- R1: While rst_n is low and after it is released, `sample` reads 0 and `new_sample` reads 0 until the first accepted word.
- R2: The word assembled from the eight data bits, first bit as bit 7 and last bit as bit 0, appears unchanged on `sample` (an 8-bit two's complement value) for every one of the 256 codes.
- R3: Every accepted word produces exactly one `new_sample` pulse, one master-clock cycle wide, and `sample` changes only in a cycle where `new_sample` is high.
- R4: If select returns high after fewer than eight rising shift-clock edges, no strobe is produced and `sample` keeps its previous value.
- R5: Rising shift-clock edges after the eighth, while select stays low, do not alter the accepted word and give no further strobe.
- R6: A word that completes before the master domain has copied the previous one is dropped. The earlier word is delivered, and the next word after the copy is accepted normally.
- R7: Rising shift-clock edges while select is high have no effect on the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sclk | input | 1 | Serial shift clock; data taken on its rising edge |
| sel_n | input | 1 | Active-low frame select; a falling edge opens a frame |
| sdata | input | 1 | Serial data, most significant bit first |
| mclk | input | 1 | Master clock of the receiving domain |
| sample | output | 8 | Most recently delivered sample, held between strobes |
| new_sample | output | 1 | One-cycle strobe in the mclk domain when `sample` is updated |

## Verification
The hardest case to reach from the ports is a second complete frame that arrives while the first word is still waiting in the holding register. With a free-running master clock, the copy finishes long before a serial frame can end. The bench therefore stops the master clock, sends two full frames and then restarts the clock. It expects only the first word and a single strobe, and then checks that a third frame is accepted once the acknowledge has come back. The other checks are a sweep over all 256 codes, aborts after every length from zero to seven bits, overlong frames and stray shift-clock pulses outside a frame.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int WORD_W_DEF = 8;

  // Append one serial bit below the bits already shifted in.
  function automatic logic [WORD_W_DEF-1:0] next_word(input logic [WORD_W_DEF-1:0] shreg,
                                                      input logic bit_in);
    return {shreg[WORD_W_DEF-2:0], bit_in};
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift
  import ssr_pkg::*;
#(
  parameter int WORD_W = WORD_W_DEF,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sel_n,
  input  logic              sdata,
  input  logic              ack_s,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] hold_word,
  output logic              req_tgl,
  output logic              word_take,
  output logic              word_drop
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              frame_rst_n;
  logic [WORD_W-1:0] shreg;
  logic              last_edge;
  logic              busy;

  // Select high holds the frame logic cleared; this is how a frame aborts.
  assign frame_rst_n = rst_n & ~sel_n;

  always_ff @(posedge sclk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (bit_cnt != FULL) begin
      bit_cnt <= bit_cnt + 1'b1;
      shreg   <= next_word(shreg, sdata);
    end
  end

  assign last_edge = (bit_cnt == LAST);
  assign busy      = req_tgl ^ ack_s;
  assign word_take = last_edge & ~busy;
  assign word_drop = last_edge & busy;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word <= '0;
      req_tgl   <= 1'b0;
    end else if (word_take) begin
      hold_word <= next_word(shreg, sdata);
      req_tgl   <= ~req_tgl;
    end
  end
endmodule

// File: rtl/ssr_deliver.sv
module ssr_deliver #(
  parameter int WORD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              mclk,
  input  logic              rst_n,
  input  logic              req_tgl,
  input  logic [WORD_W-1:0] hold_word,
  output logic [WORD_W-1:0] sample,
  output logic              new_sample,
  output logic              ack_tgl
);
  logic req_s;
  logic req_prev;
  logic req_edge;

  ssr_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(mclk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
  );

  assign req_edge = req_s ^ req_prev;

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      req_prev   <= 1'b0;
      sample     <= '0;
      new_sample <= 1'b0;
    end else begin
      req_prev   <= req_s;
      new_sample <= req_edge;
      if (req_edge) sample <= hold_word;
    end
  end

  // The acknowledge follows once the copy has been made.
  assign ack_tgl = req_prev;
endmodule

// File: rtl/serial_sample_rx.sv
module serial_sample_rx
  import ssr_pkg::*;
#(
  parameter int WORD_W      = WORD_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sel_n,
  input  logic              sdata,
  input  logic              mclk,
  output logic [WORD_W-1:0] sample,
  output logic              new_sample
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] hold_word;
  logic              req_tgl;
  logic              ack_tgl;
  logic              ack_s;
  logic              word_take;
  logic              word_drop;

  ssr_shift #(.WORD_W(WORD_W)) u_shift (
    .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdata(sdata), .ack_s(ack_s),
    .bit_cnt(bit_cnt), .hold_word(hold_word), .req_tgl(req_tgl),
    .word_take(word_take), .word_drop(word_drop)
  );

  ssr_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(sclk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s)
  );

  ssr_deliver #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_deliver (
    .mclk(mclk), .rst_n(rst_n), .req_tgl(req_tgl), .hold_word(hold_word),
    .sample(sample), .new_sample(new_sample), .ack_tgl(ack_tgl)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic          rst_n,
  input logic          sclk,
  input logic          mclk,
  input logic          sel_n,
  input logic [W-1:0]  sample,
  input logic          new_sample,
  input logic [CW-1:0] bit_cnt,
  input logic [W-1:0]  hold_word,
  input logic          req_tgl,
  input logic          word_take,
  input logic          word_drop
);
  p_strobe_width_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    new_sample |=> !new_sample);

  p_change_with_strobe_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(sample) |-> new_sample);

  p_abort_clears_r4: assert property (@(posedge mclk) disable iff (!rst_n)
    sel_n |-> (bit_cnt == '0));

  p_drop_keeps_hold_r6: assert property (@(posedge sclk) disable iff (!rst_n)
    word_drop |=> ($stable(hold_word) && $stable(req_tgl)));

  p_take_flips_req_r2: assert property (@(posedge sclk) disable iff (!rst_n)
    word_take |=> (req_tgl != $past(req_tgl)));
endmodule

bind serial_sample_rx ssr_checker #(.W(WORD_W), .CW(CNT_W)) u_chk (
  .rst_n(rst_n), .sclk(sclk), .mclk(mclk), .sel_n(sel_n),
  .sample(sample), .new_sample(new_sample), .bit_cnt(bit_cnt),
  .hold_word(hold_word), .req_tgl(req_tgl),
  .word_take(word_take), .word_drop(word_drop)
);

// File: tb/sim_serial_sample_rx.sv
`timescale 1ns/1ps
module sim_serial_sample_rx;
  localparam int MCLK_HALF = 5;
  localparam int SCLK_HALF = 7;

  logic rst_n = 1'b0, sclk = 1'b0, sel_n = 1'b1, sdata = 1'b0, mclk = 1'b0;
  logic mclk_en = 1'b1;
  logic [7:0] sample;
  logic new_sample;
  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  serial_sample_rx u0 (
    .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .sdata(sdata), .mclk(mclk),
    .sample(sample), .new_sample(new_sample)
  );

  initial forever begin
    #MCLK_HALF;
    mclk = mclk_en ? ~mclk : 1'b0;
  end

  always @(negedge mclk) if (rst_n && new_sample) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_sclk();
    #SCLK_HALF sclk = 1'b1;
    #SCLK_HALF sclk = 1'b0;
  endtask

  task automatic send(input logic [7:0] v, input int nbits, input int extra);
    sel_n = 1'b0;
    #5;
    for (int i = 0; i < nbits; i++) begin
      sdata = v[7-i];
      pulse_sclk();
    end
    for (int i = 0; i < extra; i++) begin
      sdata = ~sdata;
      pulse_sclk();
    end
    #5 sel_n = 1'b1;
    #20;
  endtask

  task automatic settle();
    repeat (8) @(negedge mclk);
  endtask

  initial begin
    int p0;
    #1;
    check("R1 reset sample", int'(sample), 0);
    check("R1 reset strobe", int'(new_sample), 0);
    #40 rst_n = 1'b1;
    settle();
    check("R1 after release sample", int'(sample), 0);
    check("R1 after release pulses", pulses, 0);

    // R2: all codes
    for (int v = 0; v < 256; v++) begin
      p0 = pulses;
      send(8'(v), 8, 0);
      settle();
      check("R2 word", int'(sample), v);
      check("R3 single strobe", pulses - p0, 1);
    end

    // R4: aborts after 0..7 bits
    send(8'h5A, 8, 0);
    settle();
    for (int n = 0; n < 8; n++) begin
      p0 = pulses;
      send(8'hC3, n, 0);
      settle();
      check("R4 abort keeps sample", int'(sample), 8'h5A);
      check("R4 abort no strobe", pulses - p0, 0);
    end

    // R5: extra edges ignored
    for (int e = 1; e < 4; e++) begin
      p0 = pulses;
      send(8'(8'h81 + e), 8, e * 3);
      settle();
      check("R5 extra edges word", int'(sample), 8'h81 + e);
      check("R5 extra edges strobe", pulses - p0, 1);
    end

    // R7: sclk pulses while select high
    for (int k = 0; k < 3; k++) begin
      sdata = 1'b1;
      pulse_sclk();
    end
    p0 = pulses;
    send(8'h26, 8, 0);
    settle();
    check("R7 stray edges word", int'(sample), 8'h26);
    check("R7 stray edges strobe", pulses - p0, 1);

    // R6: second word while holding register still full
    p0 = pulses;
    mclk_en = 1'b0;
    #50;
    send(8'hA7, 8, 0);
    send(8'h3C, 8, 0);
    mclk_en = 1'b1;
    settle();
    check("R6 first word delivered", int'(sample), 8'hA7);
    check("R6 one strobe only", pulses - p0, 1);
    p0 = pulses;
    send(8'hE9, 8, 0);
    settle();
    check("R6 next word accepted", int'(sample), 8'hE9);
    check("R6 next word strobe", pulses - p0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule